// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Intervals

This block is a supervisory timer controlled through one 32-bit control word. Software chooses a 2-bit clock prescaler code and a 2-bit interval code, then turns the timer on and, if it wants them, the interrupt and the system reset. The two codes multiply. Each prescaler step makes the tick eight times slower. Each interval step makes the count four times longer. A live system writes the restart bit again and again, usually with a read-modify-write of the current word, so that the timeout never arrives.

When the interval runs out, the block sets a sticky interrupt flag. If interrupts are enabled, it also raises an interrupt line as an early warning. A grace window of a fixed number of prescaled ticks then starts. If the window ends with no restart and the reset enable is set, the block sends out a short system-reset pulse and sets a sticky reset flag. Software clears both flags by writing 1 to them.

Software can read the enable bit back to learn whether the timer is already running, for example when it was left on by an earlier boot. To get a prompt forced restart, software writes the restart, reset-enable and enable bits together with both codes at zero.

Top module: `wdt_guard`

## Requirements
- R1: The control word uses these bits: 11:10 prescaler code, 7 enable, 6 interrupt enable, 5:4 interval code, 3 interrupt flag, 2 reset flag, 1 reset enable, 0 restart. A write loads the prescaler code, enable, interrupt enable, interval code and reset enable. All other bits always read as 0. The enable bit reads back as 1 while the timer runs.
- R2: The restart bit (bit 0) clears itself and always reads as 0.
- R3: After the synchronous active-low reset, the control word reads 0 and both the interrupt output and the system-reset output are low.
- R4: One prescaled tick lasts BASE_DIV·8^p clocks, where p is the prescaler code. The interval lasts IVAL_BASE·4^i ticks, where i is the interval code. Suppose a write that enables the timer is captured on a clock edge, and nothing is written afterwards. Then the interrupt flag (bit 3) reads 1 exactly BASE_DIV·8^p·IVAL_BASE·4^i clock edges later.
- R5: A write with bit 0 set restarts both the tick divider and the interval count from zero, and drops any grace window in progress. The other fields carried by the same write still take effect. If restarts keep arriving sooner than the timeout, the interrupt flag never sets.
- R6: The interrupt output equals the interrupt flag ANDed with interrupt enable (bit 6). Only a write with bit 3 set clears the flag. A write with bit 3 at 0 leaves the flag as it is.
- R7: After an expiry, the timer waits WIN_TICKS prescaled ticks. If reset enable (bit 1) is set when this window ends, the system-reset output is high for RST_PULSE consecutive clocks, starting one clock after the window ends. If reset enable is clear, no pulse occurs.
- R8: The reset flag (bit 2) sets on the same clock edge on which the reset pulse starts. It stays set during and after the pulse. Only a write with bit 2 set clears it.
- R9: Writing all zeros stops the timer. While the timer is disabled, neither flag sets and no reset pulse occurs.
- R10: Writing restart, reset enable and enable with both codes at 0 starts the system-reset pulse (BASE_DIV·IVAL_BASE) + (BASE_DIV·WIN_TICKS) clock edges after the write is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe for the control word |
| bus_write | input | 1 | Marks the access as a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current contents of the control word |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System-reset pulse, active high |

## Verification
The hardest state to reach from the ports is the end of the grace window. Reaching it needs an expiry, then an unbroken run of WIN_TICKS prescaled ticks, with the reset enable set and no restart at any point. At the real timing this takes far too many clocks. The bench therefore shrinks the base tick, the interval base and the window through parameters, which keeps the 8x and 4x ratios. It then sends a forced-restart write and counts clocks until the pulse starts and until it ends. The keep-alive case goes the other way: the bench sends read-modify-write restarts just inside the timeout and confirms the flag never sets. A behavioural model then follows every cycle of both cases.

// File: rtl/wdt_guard_pkg.sv
// Package: bit positions of the control word and types shared by the
// watchdog modules. Assumes a 32-bit control word.
package wdt_guard_pkg;
    localparam int WORD_W     = 32;
    localparam int B_RESTART  = 0;
    localparam int B_RST_EN   = 1;
    localparam int B_RST_FLAG = 2;
    localparam int B_IRQ_FLAG = 3;
    localparam int B_IVAL_LO  = 4;
    localparam int B_IRQ_EN   = 6;
    localparam int B_ENABLE   = 7;
    localparam int B_PRESC_LO = 10;

    typedef enum logic {
        PH_COUNT  = 1'b0,
        PH_WINDOW = 1'b1
    } wd_phase_t;

    typedef struct packed {
        logic [1:0] presc;
        logic       enable;
        logic       irq_en;
        logic [1:0] ival;
        logic       rst_en;
    } wd_cfg_t;
endpackage

// File: rtl/wdt_guard_regs.sv
// Control word storage. A write loads the configuration fields. The two
// flags are sticky: an event sets them, writing 1 clears them, and a set
// event in the same cycle wins over a clear. The restart bit is never
// stored; it only produces a one-cycle strobe. Assumes at most one access
// per clock.
module wdt_guard_regs
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              expire_i,
    input  logic              bite_i,
    output wd_cfg_t           cfg_o,
    output logic              restart_o,
    output logic              irq_flag_o,
    output logic              rst_flag_o,
    output logic [WORD_W-1:0] rdata_o
);
    logic wr;
    logic unused_wbits;

    assign wr           = bus_valid && bus_write;
    assign restart_o    = wr && bus_wdata[B_RESTART];
    assign unused_wbits = ^{bus_wdata[WORD_W-1:12], bus_wdata[9:8]};

    // Load the configuration fields on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (wr) begin
            cfg_o.presc  <= bus_wdata[B_PRESC_LO +: 2];
            cfg_o.enable <= bus_wdata[B_ENABLE];
            cfg_o.irq_en <= bus_wdata[B_IRQ_EN];
            cfg_o.ival   <= bus_wdata[B_IVAL_LO +: 2];
            cfg_o.rst_en <= bus_wdata[B_RST_EN];
        end
    end

    // Sticky flags: a set event wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_o <= 1'b0;
            rst_flag_o <= 1'b0;
        end else begin
            if (expire_i)
                irq_flag_o <= 1'b1;
            else if (wr && bus_wdata[B_IRQ_FLAG])
                irq_flag_o <= 1'b0;
            if (bite_i)
                rst_flag_o <= 1'b1;
            else if (wr && bus_wdata[B_RST_FLAG])
                rst_flag_o <= 1'b0;
        end
    end

    // Assemble the read image; the restart bit always reads 0.
    always_comb begin
        rdata_o                      = '0;
        rdata_o[B_PRESC_LO +: 2]     = cfg_o.presc;
        rdata_o[B_ENABLE]            = cfg_o.enable;
        rdata_o[B_IRQ_EN]            = cfg_o.irq_en;
        rdata_o[B_IVAL_LO +: 2]      = cfg_o.ival;
        rdata_o[B_IRQ_FLAG]          = irq_flag_o;
        rdata_o[B_RST_FLAG]          = rst_flag_o;
        rdata_o[B_RST_EN]            = cfg_o.rst_en;
        rdata_o[B_RESTART]           = 1'b0;
    end
endmodule

// File: rtl/wdt_guard_prescale.sv
// Tick divider. While running it emits one tick every BASE_DIV*8^code
// clocks. It restarts from zero on a restart strobe or while stopped.
// Assumes BASE_DIV >= 1.
module wdt_guard_prescale #(
    parameter int BASE_DIV = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] code_i,
    output logic       tick_o
);
    localparam int PW = $clog2(BASE_DIV * 512) + 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] period;

    // Period grows eightfold per code step.
    assign period = PW'(BASE_DIV) << (3 * code_i);
    assign tick_o = run_i && (pcnt >= period - 1'b1);

    // Count clocks up to the period, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run_i || clr_i || tick_o)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdt_guard_timer.sv
// Interval and grace-window sequencer. It counts ticks up to
// IVAL_BASE*4^code and then signals expiry. Next it counts WIN_TICKS ticks,
// and at the end it signals a bite if reset is enabled. A bite loads a
// pulse counter that drives the reset output for RST_PULSE clocks. A
// restart or a stop clears the sequencer but not a pulse already running.
module wdt_guard_timer
    import wdt_guard_pkg::*;
#(
    parameter int IVAL_BASE = 128,
    parameter int WIN_TICKS = 1024,
    parameter int RST_PULSE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic       tick_i,
    input  logic [1:0] ival_i,
    input  logic       rst_en_i,
    output logic       expire_o,
    output logic       bite_o,
    output logic       sys_rst_o
);
    localparam int LIM_MAX = IVAL_BASE * 64;
    localparam int C_MAX   = (LIM_MAX > WIN_TICKS) ? LIM_MAX : WIN_TICKS;
    localparam int CW      = $clog2(C_MAX) + 1;
    localparam int QW      = $clog2(RST_PULSE + 1);

    wd_phase_t     phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [QW-1:0] pulse;
    logic          step;
    logic          win_end;

    // Interval limit grows fourfold per code step.
    assign limit    = CW'(IVAL_BASE) << (2 * ival_i);
    assign step     = run_i && !clr_i && tick_i;
    assign expire_o = step && (phase == PH_COUNT) && (cnt >= limit - 1'b1);
    assign win_end  = step && (phase == PH_WINDOW) && (cnt >= CW'(WIN_TICKS - 1));
    assign bite_o   = win_end && rst_en_i;
    assign sys_rst_o = (pulse != '0);

    // Step the tick count through the interval and grace window phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || clr_i) begin
            phase <= PH_COUNT;
            cnt   <= '0;
        end else if (expire_o) begin
            phase <= PH_WINDOW;
            cnt   <= '0;
        end else if (win_end) begin
            phase <= PH_COUNT;
            cnt   <= '0;
        end else if (tick_i) begin
            cnt   <= cnt + 1'b1;
        end
    end

    // Hold the reset output high for a fixed number of clocks after a bite.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= '0;
        else if (bite_o)
            pulse <= QW'(RST_PULSE);
        else if (pulse != '0)
            pulse <= pulse - 1'b1;
    end
endmodule

// File: rtl/wdt_guard.sv
// Top of the watchdog. It connects the control word, the tick divider and
// the interval sequencer. The interrupt output is the flag gated by the
// interrupt enable. Assumes a single clock domain and a simple valid/write
// strobe.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_DIV  = 4096,
    parameter int IVAL_BASE = 128,
    parameter int WIN_TICKS = 1024,
    parameter int RST_PULSE = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o
);
    wd_cfg_t cfg;
    logic    restart;
    logic    tick;
    logic    expire;
    logic    bite;
    logic    irq_flag;
    logic    rst_flag;

    wdt_guard_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_wdata  (bus_wdata),
        .expire_i   (expire),
        .bite_i     (bite),
        .cfg_o      (cfg),
        .restart_o  (restart),
        .irq_flag_o (irq_flag),
        .rst_flag_o (rst_flag),
        .rdata_o    (bus_rdata)
    );

    wdt_guard_prescale #(.BASE_DIV(BASE_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cfg.enable),
        .clr_i  (restart),
        .code_i (cfg.presc),
        .tick_o (tick)
    );

    wdt_guard_timer #(
        .IVAL_BASE (IVAL_BASE),
        .WIN_TICKS (WIN_TICKS),
        .RST_PULSE (RST_PULSE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (cfg.enable),
        .clr_i     (restart),
        .tick_i    (tick),
        .ival_i    (cfg.ival),
        .rst_en_i  (cfg.rst_en),
        .expire_o  (expire),
        .bite_o    (bite),
        .sys_rst_o (sys_rst_o)
    );

    // Interrupt is the sticky flag gated by its enable.
    assign irq_o = irq_flag && cfg.irq_en;
endmodule

// File: rtl/wdt_guard_chk.sv
// Port-level property checker for the watchdog, attached to every instance
// of the top by the bind statement below. Assumes RST_PULSE >= 2.
module wdt_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_o,
    input logic        sys_rst_o
);
    logic wr;
    assign wr = bus_valid && bus_write;

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_rdata[3] && bus_rdata[6]));

    assert_irq_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[3] && !(wr && bus_wdata[3])) |=> bus_rdata[3]);

    assert_rst_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[2] && !(wr && bus_wdata[2])) |=> bus_rdata[2]);

    assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> bus_rdata[2]);

    assert_pulse_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |=> sys_rst_o);

    assert_idle_no_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rdata[7] && !bus_rdata[3] && !wr) |=> !bus_rdata[3]);

    assert_restart_reads_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_wdata[0]) |=> !bus_rdata[0]);
endmodule

bind wdt_guard wdt_guard_chk u_chk (.*);

// File: tb/tb_wdt_guard.sv
// Bench for the watchdog: a behavioural reference model compared on every
// clock, plus directed checks of timing, flags and reset pulses.
module tb_wdt_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TB_BASE    = 2;
    localparam int TB_IVAL    = 2;
    localparam int TB_WIN     = 4;
    localparam int TB_PULSE   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    int n_checks = 0;
    int n_err    = 0;
    bit compare_on = 1'b0;
    bit saw_rst = 1'b0;

    // Reference model state
    int m_presc, m_ival, m_pcnt, m_cnt, m_ph, m_pulse;
    bit m_en, m_ien, m_ren, m_iflag, m_rflag;

    wdt_guard #(
        .BASE_DIV (TB_BASE),
        .IVAL_BASE(TB_IVAL),
        .WIN_TICKS(TB_WIN),
        .RST_PULSE(TB_PULSE)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[11:10] = m_presc[1:0];
        w[7]     = m_en;
        w[6]     = m_ien;
        w[5:4]   = m_ival[1:0];
        w[3]     = m_iflag;
        w[2]     = m_rflag;
        w[1]     = m_ren;
        return w;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model, stepped on every rising edge
    always @(posedge clk) begin
        bit wr, rs, tick, expire, bite;
        int period, lim;
        if (!rst_n) begin
            m_presc = 0; m_ival = 0; m_pcnt = 0; m_cnt = 0; m_ph = 0; m_pulse = 0;
            m_en = 0; m_ien = 0; m_ren = 0; m_iflag = 0; m_rflag = 0;
        end else begin
            wr = bus_valid && bus_write;
            rs = wr && bus_wdata[0];
            period = TB_BASE * (8 ** m_presc);
            lim    = TB_IVAL * (4 ** m_ival);
            tick = 0; expire = 0; bite = 0;
            if (!m_en || rs) begin
                m_pcnt = 0; m_cnt = 0; m_ph = 0;
            end else begin
                if (m_pcnt >= period - 1) begin tick = 1; m_pcnt = 0; end
                else m_pcnt++;
                if (tick) begin
                    if (m_ph == 0) begin
                        if (m_cnt >= lim - 1) begin expire = 1; m_ph = 1; m_cnt = 0; end
                        else m_cnt++;
                    end else begin
                        if (m_cnt >= TB_WIN - 1) begin bite = m_ren; m_ph = 0; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
            end
            if (bite) m_pulse = TB_PULSE;
            else if (m_pulse > 0) m_pulse--;
            if (expire) m_iflag = 1;
            else if (wr && bus_wdata[3]) m_iflag = 0;
            if (bite) m_rflag = 1;
            else if (wr && bus_wdata[2]) m_rflag = 0;
            if (wr) begin
                m_presc = int'(bus_wdata[11:10]);
                m_en    = bus_wdata[7];
                m_ien   = bus_wdata[6];
                m_ival  = int'(bus_wdata[5:4]);
                m_ren   = bus_wdata[1];
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R1", "model word", int'(bus_rdata), int'(model_word()));
            chk("R6", "model irq", int'(irq_o), int'(m_iflag && m_ien));
            chk("R7", "model sys_rst", int'(sys_rst_o), int'(m_pulse > 0));
        end
        if (sys_rst_o) saw_rst = 1'b1;
    end

    task automatic wr_word(input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Edges from the last captured write until the interrupt flag reads 1
    task automatic edges_to_flag(output int n);
        n = 0;
        while (!bus_rdata[3] && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic edges_to_rst(output int n);
        n = 0;
        while (!sys_rst_o && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic timeout_case(input int p, input int iv);
        int n;
        logic [31:0] w;
        wr_word(32'h0000_000C);
        w = 32'h0000_0081;
        w[11:10] = 2'(p);
        w[5:4] = 2'(iv);
        wr_word(w);
        edges_to_flag(n);
        chk("R4", $sformatf("timeout p=%0d i=%0d", p, iv), n,
            TB_BASE * (8 ** p) * TB_IVAL * (4 ** iv));
        wr_word(32'h0000_000C);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int n, len;
        logic [31:0] w;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1'b1;

        // R3: reset state
        chk("R3", "word after reset", int'(bus_rdata), 0);
        chk("R3", "irq after reset", int'(irq_o), 0);
        chk("R3", "sys_rst after reset", int'(sys_rst_o), 0);

        // R1: field layout, unused bits read 0, timer left off
        wr_word(32'hFFFF_FF72);
        chk("R1", "field readback", int'(bus_rdata), 32'h0000_0C72);
        wr_word(32'h0);
        chk("R9", "all-zero write", int'(bus_rdata), 0);

        // R2: restart reads back 0, enable reports running
        wr_word(32'h0000_0081);
        chk("R2", "restart reads 0", int'(bus_rdata[0]), 0);
        chk("R1", "enable reads back", int'(bus_rdata[7]), 1);
        edges_to_flag(n);
        chk("R4", "timeout p=0 i=0", n, TB_BASE * TB_IVAL);
        chk("R6", "irq masked when disabled", int'(irq_o), 0);
        wr_word(32'h0000_000C);

        // R4: several prescaler/interval combinations
        timeout_case(1, 1);
        timeout_case(2, 0);
        timeout_case(0, 3);
        timeout_case(3, 0);

        // R6: interrupt gating and write-one-to-clear
        wr_word(32'h0000_00C1);
        edges_to_flag(n);
        @(negedge clk);
        chk("R6", "irq raised", int'(irq_o), 1);
        wr_word(32'h0000_00C0);
        chk("R6", "flag kept on 0 write", int'(bus_rdata[3]), 1);
        chk("R6", "irq kept", int'(irq_o), 1);
        wr_word(32'h0000_00C8);
        chk("R6", "flag cleared", int'(bus_rdata[3]), 0);
        chk("R6", "irq cleared", int'(irq_o), 0);
        wr_word(32'h0000_0000);

        // R5: keep-alive with read-modify-write restarts
        wr_word(32'h0000_0481);
        for (int k = 0; k < 10; k++) begin
            idle(20);
            w = bus_rdata | 32'h1;
            wr_word(w);
        end
        chk("R5", "no expiry under keep-alive", int'(bus_rdata[3]), 0);
        chk("R5", "fields kept", int'(bus_rdata), 32'h0000_0480);
        edges_to_flag(n);
        chk("R5", "expiry after last restart", n, TB_BASE * 8 * TB_IVAL);
        wr_word(32'h0000_000C);

        // R7: no pulse without reset enable
        saw_rst = 1'b0;
        wr_word(32'h0000_0081);
        idle(40);
        chk("R7", "no pulse when reset disabled", int'(saw_rst), 0);
        chk("R8", "no reset flag", int'(bus_rdata[2]), 0);
        wr_word(32'h0000_000C);

        // R9: stopped mid-count, nothing happens
        wr_word(32'h0000_0083);
        idle(2);
        wr_word(32'h0000_0000);
        saw_rst = 1'b0;
        idle(60);
        chk("R9", "stopped word", int'(bus_rdata), 0);
        chk("R9", "stopped no pulse", int'(saw_rst), 0);

        // R10 / R7 / R8: forced restart path
        wr_word(32'h0000_0083);
        edges_to_rst(n);
        chk("R10", "forced reset delay", n, TB_BASE * TB_IVAL + TB_BASE * TB_WIN);
        chk("R8", "reset flag with pulse", int'(bus_rdata[2]), 1);
        len = 0;
        while (sys_rst_o && len < 100) begin len++; @(negedge clk); end
        chk("R7", "pulse length", len, TB_PULSE);
        wr_word(32'h0000_0000);
        chk("R8", "reset flag after pulse and 0 write", int'(bus_rdata[2]), 1);
        wr_word(32'h0000_000C);
        chk("R8", "reset flag cleared", int'(bus_rdata[2]), 0);
        idle(5);

        compare_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule